// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory Entry

This block holds the sharer record for one memory line in a directory-based coherence scheme. It does not keep one presence bit per node. It keeps a small set of node pointers and one overflow flag. Each request names a node. A read-type request adds that node as a sharer. A write-type request asks for every other copy to be invalidated and then makes the writer the only holder of the line.

When a new distinct sharer arrives and every pointer is already in use, a 2-bit policy input decides what happens:

- **Broadcast:** the flag is set and every node is treated as a sharer.
- **Evict:** an existing pointer is taken back, round-robin, and its node is invalidated.
- **Coarse:** the same storage bits are reinterpreted as a coarse vector in which each bit covers a group of nodes.

Invalidation results appear on a registered node mask one cycle after the request. The current sharer set is shown as a node mask at all times.

Default configuration:

| Item | Value |
|---|---|
| Nodes | 16 |
| Pointers | 2, each 4 bits wide |
| Coarse vector | 8 bits, 2 nodes per bit |

Top module: `lp_dir_entry`

## Requirements
- R1: After reset the sharer mask is zero, the overflow flag is low and no invalidation is signalled.
- R2: Adding a node that is not yet recorded, while a pointer is free, records it. The sharer mask then has that node's bit set, and no invalidation is produced.
- R3: Adding a node that is already recorded leaves the sharer mask and the overflow flag unchanged and uses no pointer.
- R4: On a write by node W, the cycle after the request carries an invalidation mask. That mask equals the sharer mask before the request with bit W cleared, and the invalidation valid is high exactly when that mask is non-zero.
- R5: After a write by node W, the sharer mask is exactly bit W and the overflow flag is low, under every policy.
- R6: Policy 0, and the unused code 3, select broadcast. A distinct sharer arriving with all pointers full sets the overflow flag, and the sharer mask becomes all ones. A following write invalidates every node except the writer.
- R7: Policy 1 selects evict. A distinct sharer arriving with all pointers full replaces the pointer chosen by the victim index. The replaced node alone appears on the invalidation mask in the next cycle, and the overflow flag is never set.
- R8: Under evict, the victim index starts at pointer slot 0 after a write and advances through the slots in turn, wrapping after the last.
- R9: Policy 2 selects coarse. A distinct sharer arriving with all pointers full sets the overflow flag. In the same cycle, the stored pointers and the new node are converted into a coarse vector, in which bit k stands for nodes 2k and 2k+1. The sharer mask is then the union of those node pairs.
- R10: While the coarse vector is in use, adding a node sets the bit of its pair and produces no invalidation. A write invalidates every node covered by a set bit except the writer.
- R11: A cycle with no request changes neither the sharer mask nor the overflow flag and signals no invalidation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| policy_i | input | 2 | Overflow policy: 0 broadcast, 1 evict, 2 coarse, 3 broadcast |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write/invalidate, 0 = add sharer |
| req_node_i | input | 4 | Node named by the request |
| inv_valid_o | output | 1 | Invalidation mask is meaningful (registered) |
| inv_mask_o | output | 16 | Nodes to invalidate (registered) |
| sharers_o | output | 16 | Current sharer set as a node mask |
| overflow_o | output | 1 | Overflow flag |

## Verification
The hardest states to reach are those that need all pointers full before the deciding request arrives. Examples are the third distinct sharer under each policy, and the evict victim after one or more earlier replacements. Every such state depends on the exact history since the last write.

The bench therefore starts each trial with a write, which sets the entry to a known single pointer. It then sweeps every writer, first sharer and second sharer across all three policies, so that duplicates, free-slot adds and every overflow pairing occur. A closing write exposes the resulting sharer set on the invalidation mask. Directed sequences then chain several evictions and add sharers after the coarse conversion.

// File: rtl/lp_dir_pkg.sv
package lp_dir_pkg;
    typedef enum logic [1:0] {
        POL_BCAST  = 2'd0,
        POL_EVICT  = 2'd1,
        POL_COARSE = 2'd2
    } lp_policy_e;
endpackage

// File: rtl/lp_ptr_view.sv
// Decodes the pointer form of the storage: duplicate hit, node mask of
// the valid pointers, and the coarse-group vector those pointers map to.
module lp_ptr_view #(
    parameter int NODES = 16,
    parameter int NPTR  = 2,
    parameter int ID_W  = 4,
    parameter int CV_W  = 8,
    parameter int GRP   = 2,
    parameter int CNT_W = 2
) (
    input  logic [CV_W-1:0]  store_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [ID_W-1:0]  node_i,
    output logic             hit_o,
    output logic [NODES-1:0] mask_o,
    output logic [CV_W-1:0]  grp_o
);
    localparam logic [NODES-1:0] NODE_ONE = NODES'(1);
    localparam logic [CV_W-1:0]  GRP_ONE  = CV_W'(1);

    logic [NODES-1:0] t_mask [NPTR];
    logic [CV_W-1:0]  t_grp  [NPTR];
    logic [NPTR-1:0]  t_hit;

    for (genvar i = 0; i < NPTR; i++) begin : g_ptr
        logic [ID_W-1:0] ptr;
        logic            live;
        assign ptr        = store_i[i*ID_W +: ID_W];
        assign live       = int'(cnt_i) > i;
        assign t_mask[i]  = live ? (NODE_ONE << ptr) : '0;
        assign t_grp[i]   = live ? (GRP_ONE << (int'(ptr) / GRP)) : '0;
        assign t_hit[i]   = live && (ptr == node_i);
    end

    always_comb begin
        mask_o = '0;
        grp_o  = '0;
        for (int i = 0; i < NPTR; i++) begin
            mask_o = mask_o | t_mask[i];
            grp_o  = grp_o | t_grp[i];
        end
        hit_o = |t_hit;
    end
endmodule

// File: rtl/lp_coarse_expand.sv
// Expands a coarse vector into a node mask: each bit covers GRP nodes.
module lp_coarse_expand #(
    parameter int NODES = 16,
    parameter int CV_W  = 8,
    parameter int GRP   = 2
) (
    input  logic [CV_W-1:0]  vec_i,
    output logic [NODES-1:0] mask_o
);
    for (genvar k = 0; k < CV_W; k++) begin : g_grp
        assign mask_o[k*GRP +: GRP] = {GRP{vec_i[k]}};
    end
endmodule

// File: rtl/lp_dir_entry.sv
module lp_dir_entry #(
    parameter int NODES = 16,
    parameter int NPTR  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 policy_i,
    input  logic                       req_valid_i,
    input  logic                       req_write_i,
    input  logic [$clog2(NODES)-1:0]   req_node_i,
    output logic                       inv_valid_o,
    output logic [NODES-1:0]           inv_mask_o,
    output logic [NODES-1:0]           sharers_o,
    output logic                       overflow_o
);
    import lp_dir_pkg::*;

    localparam int ID_W  = $clog2(NODES);
    localparam int CV_W  = NPTR * ID_W;
    localparam int GRP   = NODES / CV_W;
    localparam int CNT_W = $clog2(NPTR + 1);
    localparam int RR_W  = (NPTR > 1) ? $clog2(NPTR) : 1;
    localparam logic [NODES-1:0] NODE_ONE = NODES'(1);
    localparam logic [CV_W-1:0]  GRP_ONE  = CV_W'(1);

    typedef struct packed {
        logic [CV_W-1:0]  store;  // pointers, or coarse vector once overflowed
        logic [CNT_W-1:0] cnt;    // pointers in use
        logic             ovf;
        logic [RR_W-1:0]  rr;     // evict victim slot
        logic             inv_v;
        logic [NODES-1:0] inv_m;
    } ent_t;

    ent_t s_d, s_q;

    logic             ptr_hit;
    logic [NODES-1:0] ptr_mask;
    logic [CV_W-1:0]  ptr_grp;
    logic [NODES-1:0] cv_mask;
    logic [NODES-1:0] cur_mask;
    logic [NODES-1:0] wr_mask;
    logic [ID_W-1:0]  victim;
    logic             is_cv;
    int               node_grp;

    lp_ptr_view #(
        .NODES(NODES), .NPTR(NPTR), .ID_W(ID_W),
        .CV_W(CV_W), .GRP(GRP), .CNT_W(CNT_W)
    ) u_view (
        .store_i (s_q.store),
        .cnt_i   (s_q.cnt),
        .node_i  (req_node_i),
        .hit_o   (ptr_hit),
        .mask_o  (ptr_mask),
        .grp_o   (ptr_grp)
    );

    lp_coarse_expand #(
        .NODES(NODES), .CV_W(CV_W), .GRP(GRP)
    ) u_expand (
        .vec_i  (s_q.store),
        .mask_o (cv_mask)
    );

    assign is_cv    = (policy_i == POL_COARSE);
    assign node_grp = int'(req_node_i) / GRP;
    assign cur_mask = s_q.ovf ? (is_cv ? cv_mask : '1) : ptr_mask;
    assign wr_mask  = cur_mask & ~(NODE_ONE << req_node_i);
    assign victim   = s_q.store[int'(s_q.rr)*ID_W +: ID_W];

    always_comb begin
        s_d       = s_q;
        s_d.inv_v = 1'b0;
        s_d.inv_m = '0;
        if (req_valid_i) begin
            if (req_write_i) begin
                s_d.inv_m = wr_mask;
                s_d.inv_v = |wr_mask;
                s_d.store = CV_W'(req_node_i);
                s_d.cnt   = CNT_W'(1);
                s_d.ovf   = 1'b0;
                s_d.rr    = '0;
            end else if (s_q.ovf) begin
                if (is_cv) begin
                    s_d.store[node_grp] = 1'b1;
                end
            end else if (!ptr_hit) begin
                if (int'(s_q.cnt) < NPTR) begin
                    s_d.store[int'(s_q.cnt)*ID_W +: ID_W] = req_node_i;
                    s_d.cnt = s_q.cnt + 1'b1;
                end else begin
                    case (policy_i)
                        POL_EVICT: begin
                            s_d.inv_m = NODE_ONE << victim;
                            s_d.inv_v = 1'b1;
                            s_d.store[int'(s_q.rr)*ID_W +: ID_W] = req_node_i;
                            s_d.rr = (int'(s_q.rr) == NPTR - 1) ? '0 : s_q.rr + 1'b1;
                        end
                        POL_COARSE: begin
                            s_d.store = ptr_grp | (GRP_ONE << node_grp);
                            s_d.ovf   = 1'b1;
                        end
                        default: begin
                            s_d.ovf = 1'b1;
                        end
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign inv_valid_o = s_q.inv_v;
    assign inv_mask_o  = s_q.inv_m;
    assign sharers_o   = cur_mask;
    assign overflow_o  = s_q.ovf;
endmodule

// File: rtl/lp_dir_entry_chk.sv
module lp_dir_entry_chk #(
    parameter int NODES = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [1:0]               policy_i,
    input logic                     req_valid_i,
    input logic                     req_write_i,
    input logic [$clog2(NODES)-1:0] req_node_i,
    input logic                     inv_valid_o,
    input logic [NODES-1:0]         inv_mask_o,
    input logic [NODES-1:0]         sharers_o,
    input logic                     overflow_o
);
    localparam logic [NODES-1:0] NODE_ONE = NODES'(1);

    p_write_resets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_write_i) |=>
            (!overflow_o && sharers_o == (NODE_ONE << $past(req_node_i))));

    p_writer_spared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_write_i) |=> !inv_mask_o[$past(req_node_i)]);

    p_inv_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid_o |-> (inv_mask_o != '0));

    p_add_recorded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_write_i) |=> sharers_o[$past(req_node_i)]);

    p_add_single_inv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_write_i) |=> ($countones(inv_mask_o) <= 1));

    p_evict_no_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_i == 2'd1 && !overflow_o && req_valid_i) |=> !overflow_o);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (!inv_valid_o && $stable(overflow_o) &&
                          ($stable(sharers_o) || !$stable(policy_i))));
endmodule

bind lp_dir_entry lp_dir_entry_chk #(.NODES(NODES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .policy_i    (policy_i),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_node_i  (req_node_i),
    .inv_valid_o (inv_valid_o),
    .inv_mask_o  (inv_mask_o),
    .sharers_o   (sharers_o),
    .overflow_o  (overflow_o)
);

// File: tb/lp_dir_entry_tb.sv
module lp_dir_entry_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  policy_i = 2'd0;
    logic        req_valid_i = 1'b0;
    logic        req_write_i = 1'b0;
    logic [3:0]  req_node_i = 4'd0;
    logic        inv_valid_o;
    logic [15:0] inv_mask_o;
    logic [15:0] sharers_o;
    logic        overflow_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    lp_dir_entry #(.NODES(16), .NPTR(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .policy_i(policy_i),
        .req_valid_i(req_valid_i), .req_write_i(req_write_i),
        .req_node_i(req_node_i), .inv_valid_o(inv_valid_o),
        .inv_mask_o(inv_mask_o), .sharers_o(sharers_o),
        .overflow_o(overflow_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge; results are visible at the next falling edge.
    task automatic req(input logic wr, input logic [3:0] node);
        req_valid_i = 1'b1;
        req_write_i = wr;
        req_node_i  = node;
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    function automatic logic [15:0] pair_of(input int n);
        return 16'h3 << (2 * (n / 2));
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 sharers", 32'(sharers_o), 0);
        check("R1 overflow", 32'(overflow_o), 0);
        check("R1 inv_valid", 32'(inv_valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep: policy x writer x first sharer x second sharer
        for (int p = 0; p < 3; p++) begin
            policy_i = 2'(p);
            for (int w = 0; w < 16; w++) begin
                for (int a = 0; a < 16; a++) begin
                    for (int b = 0; b < 16; b++) begin
                        int l0, l1, cnt, x;
                        logic [15:0] sh, einv;
                        logic eovf;
                        string tag;
                        req(1'b1, 4'(w));
                        l0 = w; l1 = 0; cnt = 1;
                        req(1'b0, 4'(a));
                        if (a != l0) begin l1 = a; cnt = 2; end
                        sh = (16'h1 << l0) | ((cnt == 2) ? (16'h1 << l1) : 16'h0);
                        check((a == w) ? "R3 dup sharers" : "R2 add sharers", 32'(sharers_o), 32'(sh));
                        req(1'b0, 4'(b));
                        eovf = 1'b0; einv = '0;
                        if (b == l0 || (cnt == 2 && b == l1)) begin
                            tag = "R3 dup";
                        end else if (cnt < 2) begin
                            sh  = sh | (16'h1 << b);
                            tag = "R2 add";
                        end else if (p == 0) begin
                            sh = 16'hFFFF; eovf = 1'b1; tag = "R6 bcast";
                        end else if (p == 1) begin
                            einv = 16'h1 << l0;
                            sh   = (16'h1 << b) | (16'h1 << l1);
                            tag  = "R7 evict";
                        end else begin
                            sh   = pair_of(w) | pair_of(a) | pair_of(b);
                            eovf = 1'b1;
                            tag  = "R9 coarse";
                        end
                        check({tag, " sharers"}, 32'(sharers_o), 32'(sh));
                        check({tag, " overflow"}, 32'(overflow_o), 32'(eovf));
                        check({tag, " inv_mask"}, 32'(inv_mask_o), 32'(einv));
                        x = (w + 3 * a + 5 * b) % 16;
                        req(1'b1, 4'(x));
                        einv = sh & ~(16'h1 << x);
                        check("R4 write inv_mask", 32'(inv_mask_o), 32'(einv));
                        check("R4 write inv_valid", 32'(inv_valid_o), 32'(einv != 0));
                        check("R5 after write", 32'({overflow_o, sharers_o}), 32'({1'b0, 16'h1 << x}));
                    end
                end
            end
        end

        // R8 evict round-robin across several replacements
        policy_i = 2'd1;
        req(1'b1, 4'd0);
        req(1'b0, 4'd3);
        req(1'b0, 4'd5);
        check("R8 first victim slot0", 32'(inv_mask_o), 32'h0001);
        req(1'b0, 4'd7);
        check("R8 second victim slot1", 32'(inv_mask_o), 32'h0008);
        check("R8 sharers", 32'(sharers_o), 32'h00A0);
        req(1'b0, 4'd9);
        check("R8 wrap victim slot0", 32'(inv_mask_o), 32'h0020);
        check("R7 no overflow", 32'(overflow_o), 0);

        // R10 adds after coarse conversion
        policy_i = 2'd2;
        req(1'b1, 4'd0);
        req(1'b0, 4'd4);
        req(1'b0, 4'd9);
        check("R9 coarse sharers", 32'(sharers_o), 32'h0333);
        req(1'b0, 4'd14);
        check("R10 coarse add sharers", 32'(sharers_o), 32'hC333);
        check("R10 coarse add no inv", 32'(inv_valid_o), 0);
        // R11 idle cycles
        repeat (3) @(negedge clk);
        check("R11 idle sharers", 32'(sharers_o), 32'hC333);
        check("R11 idle overflow", 32'(overflow_o), 1);
        check("R11 idle inv", 32'(inv_valid_o), 0);
        req(1'b1, 4'd1);
        check("R10 coarse write inv", 32'(inv_mask_o), 32'hC331);

        // R6 unused code 3 behaves as broadcast
        policy_i = 2'd3;
        req(1'b1, 4'd2);
        req(1'b0, 4'd3);
        req(1'b0, 4'd4);
        check("R6 code3 overflow", 32'(overflow_o), 1);
        req(1'b1, 4'd5);
        check("R6 code3 write inv", 32'(inv_mask_o), 32'hFFDF);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule